// File: doc/BRIEF.md
# Read Burst Terminate Sequencer

This block is the device-side sequencer for the read path of a double-data-rate SDRAM. On every rising clock edge it decodes the command lines: chip-select, row strobe, column strobe and write enable. A read schedules a data burst that starts after a programmed CAS latency. During the burst the block drives a rising-edge and a falling-edge data beat on every clock, together with the output enables for all data lanes and all strobes.

The burst terminate command cuts a read burst short. Its effect shows on the outputs exactly one CAS latency after the command is sampled. A terminate has meaning only while a plain read is in progress. A terminate issued during a write burst, during a read with auto-precharge, or while nothing is in flight has no effect and raises a one-cycle illegal-command flag.

The data source is the latched column address plus the beat index. A test environment can therefore predict every beat and the exact cycle on which the enables drop. The memory array, refresh, bank timing and the analog pads are outside this block.

Top module: `ddr_rd_burst_ctrl`

## Requirements
- R1: The command lines are sampled on each rising clock edge, with the lines ordered {cs_n, ras_n, cas_n, we_n}. 0101 is a read, 0100 is a write, 0110 is a burst terminate and 0111 is a no-operation. Whenever cs_n is high, nothing is decoded.
- R2: For a read sampled at edge e, the first beat pair and all enables appear after edge e+CL. CL is 2 when cfg_cl is 2'd2 and 3 for every other cfg_cl value. Both cfg_cl and cfg_bl are latched with the read.
- R3: On data cycle c of a burst, dq_rise is col+2c and dq_fall is col+2c+1. Here col is addr[9:0] of the read, zero-extended to the data width. Whenever the enables are low, both data outputs are zero.
- R4: cfg_bl 3'b001 selects burst length 2, 3'b010 selects 4 and 3'b011 selects 8. Any other code selects 4. An untruncated burst holds the enables for burst-length/2 cycles.
- R5: A terminate sampled at edge b, while a plain read is pending or delivering data, drops all enables after edge b+CL. CL is taken from cfg_cl at edge b. This also holds when the terminate arrives before the first beat has appeared, and it works for burst lengths 4 and 8.
- R6: Every bit of dq_oe and dqs_oe always carries the same value. The terminate is not selective per lane.
- R7: A terminate sampled during the write burst window leaves the outputs unaffected and sets bst_illegal for one cycle. The write burst window runs from edge w+1 to edge w+burst-length/2 after a write sampled at edge w. bst_illegal is never set by any other command.
- R8: A terminate sampled during a read whose addr[10] was 1 (auto-precharge), or sampled with no read pending or active, is ignored and sets bst_illegal for one cycle.
- R9: A new read cancels a read that has not yet launched, and it also cancels a pending terminate. A burst already delivering data continues until the new burst launches. From that point the beats restart from the new column.
- R10: While rst is high at a rising edge, all enables, data and bst_illegal are cleared, along with all pending launches, terminates and write windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| addr | input | ADDR_W (11) | Column address in [9:0], auto-precharge select in [10] |
| cfg_cl | input | 2 | CAS latency select (2 or 3) |
| cfg_bl | input | 3 | Burst length code |
| dq_rise | output | DQ_W (16) | Rising-edge data beat |
| dq_fall | output | DQ_W (16) | Falling-edge data beat |
| dq_oe | output | DQ_W/8 (2) | Data output enable, one bit per byte lane |
| dqs_oe | output | DQ_W/8 (2) | Strobe output enable, one bit per byte lane |
| bst_illegal | output | 1 | One-cycle flag for an ignored terminate |

## Verification
The bench uses the default parameters: a 16-bit data word split into two byte lanes, a 10-bit column and a longest latency of 3. With two lanes, the bench can observe that the strobe and data enables drop together rather than lane by lane. Column 0x3FE with a burst of 8 makes the beat values carry past bit 9, which shows that data is built at full word width. Both latency values and all four burst-length codes can be reached, so the bench can place a terminate before the first beat, in the middle of a burst, and against a new read that replaces it.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  localparam int PAIR_W = 3;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE,
    CMD_STOP
  } cmd_e;

  // Number of clock cycles (beat pairs) for a burst length code.
  function automatic logic [PAIR_W-1:0] pairs_for(input logic [2:0] code);
    case (code)
      3'b001:  return PAIR_W'(1);
      3'b011:  return PAIR_W'(4);
      default: return PAIR_W'(2);
    endcase
  endfunction

endpackage

// File: rtl/rdb_cmd_decode.sv
module rdb_cmd_decode
  import rdb_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b110:  cmd = CMD_STOP;
        default: cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rdb_sched.sv
module rdb_sched
  import rdb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int CL_MAX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cfg_cl,
  input  logic [2:0]        cfg_bl,
  input  logic              burst_on,
  output logic              launch,
  output logic [COL_W-1:0]  launch_col,
  output logic [PAIR_W-1:0] launch_pairs,
  output logic              stop_fire,
  output logic              rd_busy,
  output logic              wr_busy,
  output logic              rd_ap,
  output logic              bst_illegal
);

  localparam int CL_W = $clog2(CL_MAX + 1);

  logic [CL_W-1:0]   lat_cnt;
  logic [CL_W-1:0]   stop_cnt;
  logic [CL_W-1:0]   cl_eff;
  logic [PAIR_W-1:0] wr_cnt;
  logic [COL_W-1:0]  col_q;
  logic [PAIR_W-1:0] pairs_q;
  logic              ap_q;
  logic              illegal_q;
  logic              is_rd, is_wr, is_stop, stop_ok;

  assign is_rd   = (cmd == CMD_READ);
  assign is_wr   = (cmd == CMD_WRITE);
  assign is_stop = (cmd == CMD_STOP);
  assign cl_eff  = (cfg_cl == 2'd2) ? CL_W'(2) : CL_W'(CL_MAX);

  assign wr_busy = (wr_cnt != '0);
  assign rd_busy = (lat_cnt != '0) || burst_on;
  assign stop_ok = is_stop && rd_busy && !ap_q && !wr_busy;

  // A read arriving on the launch edge supersedes the one about to start.
  assign launch       = (lat_cnt == CL_W'(1)) && !is_rd;
  assign launch_col   = col_q;
  assign launch_pairs = pairs_q;
  assign stop_fire    = (stop_cnt == CL_W'(1));
  assign rd_ap        = ap_q;
  assign bst_illegal  = illegal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt  <= '0;
      stop_cnt <= '0;
      col_q    <= '0;
      pairs_q  <= '0;
      ap_q     <= 1'b0;
    end else if (is_rd) begin
      lat_cnt  <= cl_eff;
      stop_cnt <= '0;
      col_q    <= addr[COL_W-1:0];
      pairs_q  <= pairs_for(cfg_bl);
      ap_q     <= addr[AP_BIT];
    end else begin
      if (lat_cnt != '0) lat_cnt <= lat_cnt - CL_W'(1);
      if (stop_ok)              stop_cnt <= cl_eff;
      else if (stop_cnt != '0)  stop_cnt <= stop_cnt - CL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt    <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (is_wr)               wr_cnt <= pairs_for(cfg_bl);
      else if (wr_cnt != '0)   wr_cnt <= wr_cnt - PAIR_W'(1);
      illegal_q <= is_stop && !stop_ok;
    end
  end

endmodule

// File: rtl/rdb_beat_gen.sv
module rdb_beat_gen
  import rdb_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int COL_W = 10,
  parameter int LANES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [COL_W-1:0]  launch_col,
  input  logic [PAIR_W-1:0] launch_pairs,
  input  logic              stop_fire,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic [LANES-1:0]  dq_oe,
  output logic [LANES-1:0]  dqs_oe,
  output logic              burst_on
);

  logic              on_q, on_d;
  logic [PAIR_W-1:0] left_q;
  logic [DQ_W-1:0]   next_q;
  logic [DQ_W-1:0]   rise_q, fall_q;
  logic [DQ_W-1:0]   col_ext;

  assign col_ext = DQ_W'(launch_col);

  always_comb begin
    on_d = on_q;
    if (launch)                                    on_d = 1'b1;
    else if (on_q && (stop_fire || left_q == '0))  on_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      left_q <= '0;
      next_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (launch) begin
      on_q   <= 1'b1;
      left_q <= launch_pairs - PAIR_W'(1);
      rise_q <= col_ext;
      fall_q <= col_ext + DQ_W'(1);
      next_q <= col_ext + DQ_W'(2);
    end else if (on_q && !on_d) begin
      on_q   <= 1'b0;
      left_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (on_q) begin
      left_q <= left_q - PAIR_W'(1);
      rise_q <= next_q;
      fall_q <= next_q + DQ_W'(1);
      next_q <= next_q + DQ_W'(2);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic oe_r, dqs_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        oe_r  <= 1'b0;
        dqs_r <= 1'b0;
      end else begin
        oe_r  <= on_d;
        dqs_r <= on_d;
      end
    end
    assign dq_oe[i]  = oe_r;
    assign dqs_oe[i] = dqs_r;
  end

  assign dq_rise  = rise_q;
  assign dq_fall  = fall_q;
  assign burst_on = on_q;

endmodule

// File: rtl/ddr_rd_burst_ctrl.sv
module ddr_rd_burst_ctrl
  import rdb_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int ADDR_W = 11,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int CL_MAX = 3,
  localparam int LANES = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cfg_cl,
  input  logic [2:0]        cfg_bl,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic [LANES-1:0]  dq_oe,
  output logic [LANES-1:0]  dqs_oe,
  output logic              bst_illegal
);

  cmd_e              cmd;
  logic              launch, stop_fire, burst_on;
  logic              rd_busy, wr_busy, rd_ap;
  logic [COL_W-1:0]  launch_col;
  logic [PAIR_W-1:0] launch_pairs;

  rdb_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  rdb_sched #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT),
    .CL_MAX (CL_MAX)
  ) u_sched (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .addr         (addr),
    .cfg_cl       (cfg_cl),
    .cfg_bl       (cfg_bl),
    .burst_on     (burst_on),
    .launch       (launch),
    .launch_col   (launch_col),
    .launch_pairs (launch_pairs),
    .stop_fire    (stop_fire),
    .rd_busy      (rd_busy),
    .wr_busy      (wr_busy),
    .rd_ap        (rd_ap),
    .bst_illegal  (bst_illegal)
  );

  rdb_beat_gen #(
    .DQ_W  (DQ_W),
    .COL_W (COL_W),
    .LANES (LANES)
  ) u_beat (
    .clk          (clk),
    .rst          (rst),
    .launch       (launch),
    .launch_col   (launch_col),
    .launch_pairs (launch_pairs),
    .stop_fire    (stop_fire),
    .dq_rise      (dq_rise),
    .dq_fall      (dq_fall),
    .dq_oe        (dq_oe),
    .dqs_oe       (dqs_oe),
    .burst_on     (burst_on)
  );

endmodule

// File: rtl/rdb_checker.sv
module rdb_checker
  import rdb_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input cmd_e             cmd,
  input logic             wr_busy,
  input logic             rd_busy,
  input logic             rd_ap,
  input logic             launch,
  input logic             stop_fire,
  input logic [DQ_W-1:0]  dq_rise,
  input logic [DQ_W-1:0]  dq_fall,
  input logic [LANES-1:0] dq_oe,
  input logic [LANES-1:0] dqs_oe,
  input logic             bst_illegal
);

  localparam int MAX_PAIRS = 4;

  logic [3:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)             run_len <= '0;
    else if (launch)     run_len <= 4'd1;
    else if (dq_oe[0])   run_len <= run_len + 4'd1;
    else                 run_len <= '0;
  end

  assert_lanes_agree_R6: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == {LANES{dq_oe[0]}}) && (dqs_oe == dq_oe))
    else $error("lane enables disagree");

  assert_launch_opens_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> dq_oe[0])
    else $error("launch did not enable outputs");

  assert_stop_closes_R5: assert property (@(posedge clk) disable iff (rst)
    stop_fire |=> (dq_oe == '0) && (dqs_oe == '0))
    else $error("terminate did not close outputs");

  assert_burst_cap_R4: assert property (@(posedge clk) disable iff (rst)
    dq_oe[0] |-> (run_len <= 4'(MAX_PAIRS)))
    else $error("burst longer than maximum");

  assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !dq_oe[0] |-> (dq_rise == '0) && (dq_fall == '0))
    else $error("data nonzero while disabled");

  assert_fall_follows_R3: assert property (@(posedge clk) disable iff (rst)
    dq_oe[0] |-> (dq_fall == dq_rise + DQ_W'(1)))
    else $error("fall beat not rise+1");

  assert_wr_bst_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STOP && wr_busy) |=> bst_illegal)
    else $error("terminate in write not flagged");

  assert_flag_only_on_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_STOP) |=> !bst_illegal)
    else $error("flag without terminate");

  assert_ap_bst_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STOP && rd_busy && rd_ap) |=> bst_illegal)
    else $error("terminate in auto-precharge read not flagged");

  assert_idle_bst_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STOP && !rd_busy) |=> bst_illegal)
    else $error("idle terminate not flagged");

endmodule

bind ddr_rd_burst_ctrl rdb_checker #(
  .DQ_W  (DQ_W),
  .LANES (LANES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd         (cmd),
  .wr_busy     (wr_busy),
  .rd_busy     (rd_busy),
  .rd_ap       (rd_ap),
  .launch      (launch),
  .stop_fire   (stop_fire),
  .dq_rise     (dq_rise),
  .dq_fall     (dq_fall),
  .dq_oe       (dq_oe),
  .dqs_oe      (dqs_oe),
  .bst_illegal (bst_illegal)
);

// File: tb/ddr_rd_burst_ctrl_test.sv
module ddr_rd_burst_ctrl_test;

  localparam int DQ_W   = 16;
  localparam int ADDR_W = 11;
  localparam int LANES  = DQ_W / 8;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_RD   = 4'b0101;
  localparam logic [3:0] C_WR   = 4'b0100;
  localparam logic [3:0] C_BST  = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0] cfg_cl = 2'd3;
  logic [2:0] cfg_bl = 3'b010;
  logic [DQ_W-1:0]  dq_rise, dq_fall;
  logic [LANES-1:0] dq_oe, dqs_oe;
  logic bst_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ddr_rd_burst_ctrl uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
    .dqs_oe(dqs_oe), .bst_illegal(bst_illegal)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [ADDR_W-1:0] a);
    {cs_n, ras_n, cas_n, we_n} = c;
    addr = a;
  endtask

  task automatic verify(input string tag, input int k, input bit on,
                        input logic [DQ_W-1:0] rise, input bit ill);
    logic [LANES-1:0] eo;
    logic [DQ_W-1:0]  er, ef;
    string t;
    eo = on ? '1 : '0;
    er = on ? rise : '0;
    ef = on ? rise + DQ_W'(1) : '0;
    t  = $sformatf("%s k=%0d", tag, k);
    check(dq_oe == eo,          t, "dq_oe",       32'(dq_oe),       32'(eo));
    check(dqs_oe == eo,         t, "dqs_oe",      32'(dqs_oe),      32'(eo));
    check(dq_rise == er,        t, "dq_rise",     32'(dq_rise),     32'(er));
    check(dq_fall == ef,        t, "dq_fall",     32'(dq_fall),     32'(ef));
    check(bst_illegal == ill,   t, "bst_illegal", 32'(bst_illegal), 32'(ill));
  endtask

  // One read, optional terminate sampled at edge bst_at (0 = none).
  task automatic read_case(input string tag, input logic [1:0] cl, input logic [2:0] blc,
                           input logic [9:0] col, input bit ap, input int bst_at);
    int lat, pairs, stop_k;
    bit on;
    lat    = (cl == 2'd2) ? 2 : 3;
    pairs  = (blc == 3'b001) ? 1 : (blc == 3'b011) ? 4 : 2;
    stop_k = (bst_at > 0 && !ap) ? bst_at + lat : 1000;
    @(negedge clk);
    cfg_cl = cl;
    cfg_bl = blc;
    drive(C_RD, {ap, col});
    @(negedge clk);
    for (int k = 0; k < 14; k++) begin
      if (k + 1 == bst_at) drive(C_BST, '0);
      else                 drive(C_NOP, '0);
      on = (k >= lat) && (k < lat + pairs) && (k < stop_k);
      verify(tag, k, on, DQ_W'(col) + DQ_W'(2 * (k - lat)), (k == bst_at) && ap);
      @(negedge clk);
    end
  endtask

  task automatic reset_case();
    rst = 1'b1;
    drive(C_NOP, '0);
    repeat (3) @(negedge clk);
    verify("R10 reset", 0, 1'b0, '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic reset_mid_burst();
    @(negedge clk);
    cfg_cl = 2'd2; cfg_bl = 3'b011;
    drive(C_RD, 11'h010);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      drive(C_NOP, '0);
      rst = (k == 3);
      if (k < 2)      verify("R10 mid", k, 1'b0, '0, 1'b0);
      else if (k < 4) verify("R10 mid", k, 1'b1, DQ_W'(16'h010 + 2 * (k - 2)), 1'b0);
      else            verify("R10 cleared", k, 1'b0, '0, 1'b0);
      @(negedge clk);
    end
    rst = 1'b0;
  endtask

  task automatic deselect_case();
    @(negedge clk);
    cfg_cl = 2'd2; cfg_bl = 3'b010;
    drive(4'b1101, 11'h033);
    @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      if (k == 0) drive(4'b1110, '0);
      else        drive(C_NOP, '0);
      verify("R1 deselect", k, 1'b0, '0, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic idle_bst_case();
    @(negedge clk);
    drive(C_BST, '0);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      drive(C_NOP, '0);
      verify("R8 idle", k, 1'b0, '0, k == 0);
      @(negedge clk);
    end
  endtask

  task automatic write_in_read_case();
    bit on;
    @(negedge clk);
    cfg_cl = 2'd3; cfg_bl = 3'b011;
    drive(C_RD, 11'h0A0);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      if (k == 0)      drive(C_WR, '0);
      else if (k == 1) drive(C_BST, '0);
      else             drive(C_NOP, '0);
      on = (k >= 3) && (k < 7);
      verify("R7 write", k, on, DQ_W'(16'h0A0 + 2 * (k - 3)), k == 2);
      @(negedge clk);
    end
  endtask

  task automatic restart_prelaunch_case();
    bit on;
    @(negedge clk);
    cfg_cl = 2'd3; cfg_bl = 3'b011;
    drive(C_RD, 11'h111);
    @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      if (k == 0)      drive(C_BST, '0);
      else if (k == 1) drive(C_RD, 11'h2A0);
      else             drive(C_NOP, '0);
      on = (k >= 5) && (k < 9);
      verify("R9 prelaunch", k, on, DQ_W'(16'h2A0 + 2 * (k - 5)), 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic restart_mid_case();
    @(negedge clk);
    cfg_cl = 2'd2; cfg_bl = 3'b011;
    drive(C_RD, 11'h040);
    @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      if (k == 2) begin
        cfg_bl = 3'b001;
        drive(C_RD, 11'h300);
      end else begin
        drive(C_NOP, '0);
      end
      if (k < 2)       verify("R9 mid", k, 1'b0, '0, 1'b0);
      else if (k < 5)  verify("R9 mid", k, 1'b1, DQ_W'(16'h040 + 2 * (k - 2)), 1'b0);
      else if (k == 5) verify("R9 mid", k, 1'b1, 16'h0300, 1'b0);
      else             verify("R9 mid", k, 1'b0, '0, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    reset_case();
    read_case("R2 R3 bl4 cl3",       2'd3, 3'b010, 10'h120, 1'b0, 0);
    read_case("R2 R4 bl2 cl2",       2'd2, 3'b001, 10'h3FE, 1'b0, 0);
    read_case("R3 R4 bl8 carry",     2'd2, 3'b011, 10'h3FE, 1'b0, 0);
    read_case("R2 R4 code7 cl0",     2'd0, 3'b111, 10'h055, 1'b0, 0);
    read_case("R5 R6 bl8 cl3 mid",   2'd3, 3'b011, 10'h200, 1'b0, 3);
    read_case("R5 R6 bl4 cl2",       2'd2, 3'b010, 10'h0C0, 1'b0, 1);
    read_case("R5 pending bl8 cl3",  2'd3, 3'b011, 10'h1F0, 1'b0, 1);
    read_case("R8 autoprecharge",    2'd3, 3'b011, 10'h0E0, 1'b1, 3);
    idle_bst_case();
    write_in_read_case();
    deselect_case();
    restart_prelaunch_case();
    restart_mid_case();
    reset_mid_burst();
    done = 1'b1;
    finish_run();
  end

endmodule